// File: doc/BRIEF.md
# Lockable General-Purpose I/O Port

This block is a sixteen-pin digital I/O port controlled through a 32-bit word-addressed register interface. Each pin has its own fields that select its mode, output type, drive speed, pull control and alternate-function channel. The port also has an output data register, an input data register that takes a fresh sample of the pin levels on every clock, and a lock register. Pad electronics stay outside the block. The port drives only digital controls: the output value, the output enable, a 2-bit pull request and a 2-bit speed code for each pin.

Software can freeze the configuration of chosen pins until the next reset. It does this with a key sequence on the lock register: three full-word writes of the same pin mask, with the key bit at position 16 set to 1, then 0, then 1, followed by one read of the lock register. Each pin carries a 4-bit alternate-function selector. That selector chooses which of sixteen peripheral channels drives the pin, and it also chooses which channel input receives the pin's sampled level. A pin is therefore connected to only one channel at a time.

The register map uses word offsets on `addr_i`: 0 mode, 1 output type, 2 speed, 3 pull, 4 input data, 5 output data, 6 lock, 7 alternate-function low, 8 alternate-function high. Any other offset reads as 0 and writes to it are ignored.

Top module: `gpio_lock_port`

## Requirements
- R1: While a pin is locked, writes leave that pin's fields unchanged in the mode, output-type, speed, pull, alternate-function-low and alternate-function-high registers. Fields of unlocked pins are still written.
- R2: A write to the lock register (offset 6) whose byte enables are not all four ones has no effect, neither on the stored mask nor on the key sequence.
- R3: The lock becomes active only after this exact order of accesses to the lock register: full-word writes with bit 16 = 1, then 0, then 1, all three with identical bits [15:0], then a read of the lock register. After that, bit 16 of the lock register reads 1 and bits [15:0] give the locked pin mask.
- R4: Any other access to the lock register during the sequence sends the sequence back to its start without locking. This includes a wrong key value, changed bits [15:0], an early read, or a write after the third step.
- R5: Once the lock is active, the lock register and the locked fields keep their values until rst_ni is asserted. Reset clears every register to 0 and releases the lock.
- R6: Pin p takes its 4-bit alternate-function selector from bits [4p+3:4p] of offset 7 for pins 0 to 7, and from bits [4(p-8)+3:4(p-8)] of offset 8 for pins 8 to 15. In mode 10 the pin's output value is af_dout_i[sel*16+p].
- R7: af_din_o[sel*16+p] carries pin p's input-data bit when pin p is in mode 10. Every other bit of af_din_o that belongs to pin p is 0.
- R8: Mode bits [2p+1:2p] at offset 0 encode 00 input, 01 output, 10 alternate and 11 analog. Only modes 01 and 10 drive: pin_o[p] then carries output-data bit p (mode 01) or the selected channel (mode 10). In modes 00 and 11, pin_o[p] and pin_oe_o[p] are both 0.
- R9: Output-type bit p at offset 1 selects push-pull (0), where pin_oe_o[p] is 1 in a driving mode, or open-drain (1), where pin_oe_o[p] is 1 only while pin_o[p] is 0.
- R10: pull_o[2p+1:2p] follows the pin's pull field at offset 3 in modes 00, 01 and 10, and is 00 in analog mode. speed_o is a copy of the register at offset 2.
- R11: The input-data register (offset 4, bits [15:0]) takes in pin_i on every clock edge, so a read returns the pin levels from the previous cycle.
- R12: Writes to offsets 0, 1, 2, 3, 5, 7 and 8 update only the bytes whose byte enable (be_i[k] for bits [8k+7:8k]) is 1. Reads return the stored value. Bits above a register's width read as 0, and rdata_o is 0 when no read is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Word offset |
| be_i | input | 4 | Byte enables for the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid combinationally while a read is requested |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Output value for each pin |
| pin_oe_o | output | 16 | Output enable for each pin |
| pull_o | output | 32 | 2-bit pull request for each pin |
| speed_o | output | 32 | 2-bit speed code for each pin |
| af_dout_i | input | 256 | Peripheral channel outputs, index channel*16+pin |
| af_din_o | output | 256 | Pin levels routed to peripheral channels, index channel*16+pin |

## Verification
The assertions assume that each register access lasts exactly one cycle with stable address, enables and data. They also assume that a read of the lock register counts as one step of the key sequence, so reads of offset 6 never repeat by themselves. The bench issues every access as a single-cycle pulse between falling edges, reads the lock register only when it means to, and samples the outputs half a cycle after each edge. Its random accesses use random byte enables and data, so they hit locked and unlocked fields, narrow and full lock writes, and every mode and selector value, all against a model of the key sequence kept in the bench.

// File: rtl/gpio_lock_pkg.sv
package gpio_lock_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    MD_IN  = 2'b00,
    MD_OUT = 2'b01,
    MD_ALT = 2'b10,
    MD_ANA = 2'b11
  } pin_mode_e;

  localparam logic [3:0] RA_MODE  = 4'd0;
  localparam logic [3:0] RA_OTYPE = 4'd1;
  localparam logic [3:0] RA_SPEED = 4'd2;
  localparam logic [3:0] RA_PULL  = 4'd3;
  localparam logic [3:0] RA_IDR   = 4'd4;
  localparam logic [3:0] RA_ODR   = 4'd5;
  localparam logic [3:0] RA_LOCK  = 4'd6;
  localparam logic [3:0] RA_AFLO  = 4'd7;
  localparam logic [3:0] RA_AFHI  = 4'd8;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_KEY1,
    LK_KEY0,
    LK_KEY1B
  } lk_state_e;

  function automatic logic [DW-1:0] merge_bits(logic [DW-1:0] old_v,
                                               logic [DW-1:0] new_v,
                                               logic [DW-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction
endpackage

// File: rtl/gpio_lock_seq.sv
module gpio_lock_seq
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,     // full-word write to lock register
  input  logic             rd_i,     // read of lock register
  input  logic             wkey_i,
  input  logic [NPINS-1:0] wpat_i,
  output logic             locked_o,
  output logic [NPINS-1:0] pat_o,
  output logic [NPINS-1:0] lock_mask_o
);
  lk_state_e        st_q;
  logic             locked_q;
  logic [NPINS-1:0] pat_q;
  logic [NPINS-1:0] seq_pat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= LK_IDLE;
      locked_q  <= 1'b0;
      pat_q     <= '0;
      seq_pat_q <= '0;
    end else if (!locked_q) begin
      if (wr_i) begin
        pat_q <= wpat_i;
        unique case (st_q)
          LK_IDLE: begin
            st_q      <= wkey_i ? LK_KEY1 : LK_IDLE;
            seq_pat_q <= wpat_i;
          end
          LK_KEY1: st_q <= (!wkey_i && wpat_i == seq_pat_q) ? LK_KEY0 : LK_IDLE;
          LK_KEY0: st_q <= (wkey_i && wpat_i == seq_pat_q) ? LK_KEY1B : LK_IDLE;
          default: st_q <= LK_IDLE;
        endcase
      end else if (rd_i) begin
        if (st_q == LK_KEY1B) locked_q <= 1'b1;
        st_q <= LK_IDLE;
      end
    end
  end

  assign locked_o    = locked_q;
  assign pat_o       = pat_q;
  assign lock_mask_o = locked_q ? pat_q : '0;

  // R5
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);

  // R5
  lock_pat_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> $stable(pat_q));

  // R3
  lock_arm_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(rd_i && !wr_i && st_q == LK_KEY1B));

  // R4
  lock_seq_wrongkey_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_q && wr_i && st_q == LK_KEY1 && wkey_i) |=> st_q == LK_IDLE);
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned SELW  = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [3:0]            addr_i,
  input  logic [3:0]            be_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NPINS-1:0]      lock_mask_i,
  output logic [2*NPINS-1:0]    mode_o,
  output logic [NPINS-1:0]      otype_o,
  output logic [2*NPINS-1:0]    speed_o,
  output logic [2*NPINS-1:0]    pull_o,
  output logic [SELW*NPINS-1:0] af_o,
  output logic [NPINS-1:0]      odr_o
);
  localparam int unsigned AFW = SELW * NPINS;
  localparam int unsigned ZW  = DW - NPINS;

  logic [DW-1:0]      bem;
  logic [2*NPINS-1:0] lk2;
  logic [AFW-1:0]     lk4;
  logic [2*NPINS-1:0] mode_q, speed_q, pull_q;
  logic [NPINS-1:0]   otype_q, odr_q;
  logic [AFW-1:0]     af_q;
  logic [DW-1:0]      otype_nx, odr_nx;

  always_comb begin
    for (int i = 0; i < DW; i++) bem[i] = be_i[i/8];
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_lk
    assign lk2[2*p +: 2]       = {2{lock_mask_i[p]}};
    assign lk4[SELW*p +: SELW] = {SELW{lock_mask_i[p]}};
  end

  assign otype_nx = merge_bits({{ZW{1'b0}}, otype_q}, wdata_i, bem & ~{{ZW{1'b0}}, lock_mask_i});
  assign odr_nx   = merge_bits({{ZW{1'b0}}, odr_q}, wdata_i, bem);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      otype_q <= '0;
      speed_q <= '0;
      pull_q  <= '0;
      af_q    <= '0;
      odr_q   <= '0;
    end else if (wr_i) begin
      unique case (addr_i)
        RA_MODE:  mode_q  <= merge_bits(mode_q, wdata_i, bem & ~lk2);
        RA_OTYPE: otype_q <= otype_nx[NPINS-1:0];
        RA_SPEED: speed_q <= merge_bits(speed_q, wdata_i, bem & ~lk2);
        RA_PULL:  pull_q  <= merge_bits(pull_q, wdata_i, bem & ~lk2);
        RA_ODR:   odr_q   <= odr_nx[NPINS-1:0];
        RA_AFLO:  af_q[DW-1:0]   <= merge_bits(af_q[DW-1:0], wdata_i, bem & ~lk4[DW-1:0]);
        RA_AFHI:  af_q[AFW-1:DW] <= merge_bits(af_q[AFW-1:DW], wdata_i, bem & ~lk4[AFW-1:DW]);
        default: ;
      endcase
    end
  end

  assign mode_o  = mode_q;
  assign otype_o = otype_q;
  assign speed_o = speed_q;
  assign pull_o  = pull_q;
  assign af_o    = af_q;
  assign odr_o   = odr_q;

  // R1
  mode_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_mask_i == $past(lock_mask_i)) |-> (((mode_q ^ $past(mode_q)) & lk2) == '0));

  // R1
  af_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_mask_i == $past(lock_mask_i)) |-> (((af_q ^ $past(af_q)) & lk4) == '0));

  // R1
  pull_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_mask_i == $past(lock_mask_i)) |-> (((pull_q ^ $past(pull_q)) & lk2) == '0));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned NAF   = 16,
  parameter int unsigned SELW  = $clog2(NAF)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [2*NPINS-1:0]    mode_i,
  input  logic [NPINS-1:0]      otype_i,
  input  logic [NPINS-1:0]      odr_i,
  input  logic [2*NPINS-1:0]    pull_cfg_i,
  input  logic [SELW*NPINS-1:0] af_sel_i,
  input  logic [NPINS-1:0]      idr_i,
  input  logic [NAF*NPINS-1:0]  af_dout_i,
  output logic [NPINS-1:0]      pin_o,
  output logic [NPINS-1:0]      pin_oe_o,
  output logic [2*NPINS-1:0]    pull_o,
  output logic [NAF*NPINS-1:0]  af_din_o
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    pin_mode_e       md;
    logic [SELW-1:0] sel;
    logic            drv, val;
    logic [NAF-1:0]  din_col;

    assign md  = pin_mode_e'(mode_i[2*p +: 2]);
    assign sel = af_sel_i[SELW*p +: SELW];
    assign drv = (md == MD_OUT) || (md == MD_ALT);
    assign val = (md == MD_OUT) ? odr_i[p] : af_dout_i[sel*NPINS + p];

    assign pin_o[p]       = drv & val;
    assign pin_oe_o[p]    = drv & (~otype_i[p] | ~val);
    assign pull_o[2*p +: 2] = (md == MD_ANA) ? 2'b00 : pull_cfg_i[2*p +: 2];

    for (genvar c = 0; c < NAF; c++) begin : g_ch
      assign din_col[c] = (md == MD_ALT) && (sel == c[SELW-1:0]) && idr_i[p];
      assign af_din_o[c*NPINS + p] = din_col[c];
    end

    // R8
    nodrive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i[2*p +: 2] == 2'b00 || mode_i[2*p +: 2] == 2'b11) |-> (!pin_oe_o[p] && !pin_o[p]));

    // R9
    od_low_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (otype_i[p] && pin_oe_o[p]) |-> !pin_o[p]);

    // R7
    single_channel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(din_col));
  end
endmodule

// File: rtl/gpio_lock_port.sv
module gpio_lock_port
  import gpio_lock_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned NAF   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [3:0]           addr_i,
  input  logic [3:0]           be_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NPINS-1:0]     pin_i,
  output logic [NPINS-1:0]     pin_o,
  output logic [NPINS-1:0]     pin_oe_o,
  output logic [2*NPINS-1:0]   pull_o,
  output logic [2*NPINS-1:0]   speed_o,
  input  logic [NAF*NPINS-1:0] af_dout_i,
  output logic [NAF*NPINS-1:0] af_din_o
);
  localparam int unsigned SELW = $clog2(NAF);
  localparam int unsigned AFW  = SELW * NPINS;
  localparam int unsigned ZW   = DW - NPINS;

  logic                 wr, rd, lk_wr, lk_rd, locked;
  logic [NPINS-1:0]     lk_pat, lock_mask, otype, odr;
  logic [NPINS-1:0]     idr_q;
  logic [2*NPINS-1:0]   mode, speed, pull_cfg;
  logic [AFW-1:0]       af_sel;

  assign wr    = req_i & we_i;
  assign rd    = req_i & ~we_i;
  assign lk_wr = wr && addr_i == RA_LOCK && be_i == 4'hF;
  assign lk_rd = rd && addr_i == RA_LOCK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idr_q <= '0;
    else         idr_q <= pin_i;
  end

  gpio_lock_seq #(.NPINS(NPINS)) u_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (lk_wr),
    .rd_i        (lk_rd),
    .wkey_i      (wdata_i[NPINS]),
    .wpat_i      (wdata_i[NPINS-1:0]),
    .locked_o    (locked),
    .pat_o       (lk_pat),
    .lock_mask_o (lock_mask)
  );

  gpio_cfg_regs #(.NPINS(NPINS), .SELW(SELW)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr),
    .addr_i      (addr_i),
    .be_i        (be_i),
    .wdata_i     (wdata_i),
    .lock_mask_i (lock_mask),
    .mode_o      (mode),
    .otype_o     (otype),
    .speed_o     (speed),
    .pull_o      (pull_cfg),
    .af_o        (af_sel),
    .odr_o       (odr)
  );

  gpio_pin_mux #(.NPINS(NPINS), .NAF(NAF), .SELW(SELW)) u_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .otype_i    (otype),
    .odr_i      (odr),
    .pull_cfg_i (pull_cfg),
    .af_sel_i   (af_sel),
    .idr_i      (idr_q),
    .af_dout_i  (af_dout_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .pull_o     (pull_o),
    .af_din_o   (af_din_o)
  );

  assign speed_o = speed;

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        RA_MODE:  rdata_o = mode;
        RA_OTYPE: rdata_o = {{ZW{1'b0}}, otype};
        RA_SPEED: rdata_o = speed;
        RA_PULL:  rdata_o = pull_cfg;
        RA_IDR:   rdata_o = {{ZW{1'b0}}, idr_q};
        RA_ODR:   rdata_o = {{ZW{1'b0}}, odr};
        RA_LOCK:  rdata_o = {{(ZW-1){1'b0}}, locked, lk_pat};
        RA_AFLO:  rdata_o = af_sel[DW-1:0];
        RA_AFHI:  rdata_o = af_sel[AFW-1:DW];
        default:  rdata_o = '0;
      endcase
    end
  end

  // R2
  narrow_lock_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == RA_LOCK && be_i != 4'hF) |=> ($stable(lk_pat) && $stable(locked)));

  // R11
  idr_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> idr_q == $past(pin_i));
endmodule

// File: tb/gpio_lock_port_test.sv
module gpio_lock_port_test;
  localparam int N   = 16;
  localparam int NAF = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            req_i = 1'b0, we_i = 1'b0;
  logic [3:0]      addr_i = '0, be_i = '0;
  logic [31:0]     wdata_i = '0, rdata_o;
  logic [N-1:0]    pin_i = '0, pin_o, pin_oe_o;
  logic [2*N-1:0]  pull_o, speed_o;
  logic [NAF*N-1:0] af_dout_i = '0, af_din_o;

  always #2 clk = ~clk;

  gpio_lock_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .pull_o(pull_o), .speed_o(speed_o), .af_dout_i(af_dout_i),
    .af_din_o(af_din_o)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [31:0] m_mode, m_speed, m_pull;
  logic [15:0] m_otype, m_odr, m_lpat, m_seq, m_idr;
  logic [63:0] m_af;
  bit          m_lkd;
  int          m_ls;

  task automatic model_reset();
    m_mode = 0; m_speed = 0; m_pull = 0; m_otype = 0; m_odr = 0;
    m_lpat = 0; m_seq = 0; m_idr = 0; m_af = 0; m_lkd = 0; m_ls = 0;
  endtask

  task automatic check(string tag, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] lmask();
    return m_lkd ? m_lpat : 16'h0;
  endfunction

  function automatic logic [31:0] bytemask(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] lk2();
    logic [31:0] r;
    for (int p = 0; p < 16; p++) r[2*p +: 2] = {2{lmask()[p]}};
    return r;
  endfunction

  function automatic logic [63:0] lk4();
    logic [63:0] r;
    for (int p = 0; p < 16; p++) r[4*p +: 4] = {4{lmask()[p]}};
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(logic [3:0] a);
    case (a)
      4'd0: return m_mode;
      4'd1: return {16'h0, m_otype};
      4'd2: return m_speed;
      4'd3: return m_pull;
      4'd4: return {16'h0, m_idr};
      4'd5: return {16'h0, m_odr};
      4'd6: return {15'h0, m_lkd, m_lpat};
      4'd7: return m_af[31:0];
      4'd8: return m_af[63:32];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    logic [31:0] bm, m;
    bm = bytemask(be);
    case (a)
      4'd0: begin m = bm & ~lk2(); m_mode  = (m_mode & ~m) | (d & m); end
      4'd1: begin m = bm & ~{16'h0, lmask()}; m_otype = (m_otype & ~m[15:0]) | (d[15:0] & m[15:0]); end
      4'd2: begin m = bm & ~lk2(); m_speed = (m_speed & ~m) | (d & m); end
      4'd3: begin m = bm & ~lk2(); m_pull  = (m_pull & ~m) | (d & m); end
      4'd5: m_odr = (m_odr & ~bm[15:0]) | (d[15:0] & bm[15:0]);
      4'd7: begin m = bm & ~lk4()[31:0];  m_af[31:0]  = (m_af[31:0] & ~m) | (d & m); end
      4'd8: begin m = bm & ~lk4()[63:32]; m_af[63:32] = (m_af[63:32] & ~m) | (d & m); end
      4'd6: if (be == 4'hF && !m_lkd) begin
        m_lpat = d[15:0];
        case (m_ls)
          0: begin m_ls = d[16] ? 1 : 0; m_seq = d[15:0]; end
          1: m_ls = (!d[16] && d[15:0] == m_seq) ? 2 : 0;
          2: m_ls = (d[16] && d[15:0] == m_seq) ? 3 : 0;
          default: m_ls = 0;
        endcase
      end
      default: ;
    endcase
  endtask

  task automatic model_rd(logic [3:0] a);
    if (a == 4'd6 && !m_lkd) begin
      if (m_ls == 3) m_lkd = 1;
      m_ls = 0;
    end
  endtask

  task automatic bus_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; be_i = be;
    @(negedge clk);
    req_i = 0; we_i = 0;
    model_wr(a, d, be);
  endtask

  task automatic bus_rd(logic [3:0] a, string tag);
    logic [31:0] exp;
    @(negedge clk);
    req_i = 1; we_i = 0; addr_i = a;
    exp = exp_rd(a);
    #1 check(tag, {224'h0, rdata_o}, {224'h0, exp});
    @(negedge clk);
    req_i = 0;
    model_rd(a);
  endtask

  task automatic chk_pins(string tag);
    logic [15:0]  e_out, e_oe;
    logic [31:0]  e_pull;
    logic [255:0] e_din;
    e_din = '0;
    for (int p = 0; p < 16; p++) begin
      logic [1:0] md;
      logic [3:0] sel;
      logic       val;
      md  = m_mode[2*p +: 2];
      sel = m_af[4*p +: 4];
      val = (md == 2'b01) ? m_odr[p] : af_dout_i[sel*16 + p];
      if (md == 2'b01 || md == 2'b10) begin
        e_out[p] = val;
        e_oe[p]  = m_otype[p] ? ~val : 1'b1;
      end else begin
        e_out[p] = 0; e_oe[p] = 0;
      end
      e_pull[2*p +: 2] = (md == 2'b11) ? 2'b00 : m_pull[2*p +: 2];
      if (md == 2'b10) e_din[sel*16 + p] = m_idr[p];
    end
    check({tag, " R8 pin_o"},     {240'h0, pin_o},    {240'h0, e_out});
    check({tag, " R9 pin_oe_o"},  {240'h0, pin_oe_o}, {240'h0, e_oe});
    check({tag, " R10 pull_o"},   {224'h0, pull_o},   {224'h0, e_pull});
    check({tag, " R10 speed_o"},  {224'h0, speed_o},  {224'h0, m_speed});
    check({tag, " R6 R7 af_din"}, af_din_o, e_din);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  function automatic logic [3:0] pick_addr();
    logic [3:0] t[7] = '{4'd0, 4'd1, 4'd2, 4'd3, 4'd5, 4'd7, 4'd8};
    return t[$urandom_range(0, 6)];
  endfunction

  task automatic random_phase(int n, string tag);
    for (int i = 0; i < n; i++) begin
      logic [3:0] a;
      pin_i = $urandom;
      if ($urandom_range(0, 9) == 0) a = 4'd6; else a = pick_addr();
      bus_wr(a, $urandom, 4'($urandom_range(0, 15)));
      m_idr = pin_i;
      if ($urandom_range(0, 3) == 0) bus_rd(pick_addr(), {tag, " R12 readback"});
      else if ($urandom_range(0, 1) == 0) bus_rd(a == 4'd6 ? 4'd0 : a, {tag, " R1 R12 readback"});
      chk_pins(tag);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    for (int k = 0; k < 8; k++) af_dout_i[32*k +: 32] = $urandom;
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // reset state
    bus_rd(4'd0, "R5 reset mode");
    bus_rd(4'd6, "R5 reset lock");
    chk_pins("R8 reset");

    // directed modes
    bus_wr(4'd0, 32'h0000_E4E4, 4'hF);          // modes 0,1,2,3 repeating
    bus_wr(4'd5, 32'h0000_AAAA, 4'hF);
    bus_wr(4'd1, 32'h0000_0F0F, 4'hF);          // some open-drain
    bus_wr(4'd3, 32'h5555_AAAA, 4'hF);
    bus_wr(4'd7, 32'h7654_3210, 4'hF);
    bus_wr(4'd8, 32'hFEDC_BA98, 4'hF);
    pin_i = 16'hFFFF;
    @(negedge clk); m_idr = pin_i;
    chk_pins("R6 R8 R9 R10 directed");
    bus_rd(4'd7, "R6 af low");
    bus_rd(4'd8, "R6 af high");

    // R11 input sampling
    pin_i = 16'hC3A5;
    @(negedge clk); m_idr = pin_i;
    bus_rd(4'd4, "R11 idr");
    pin_i = 16'h1E87;
    @(negedge clk); m_idr = pin_i;
    bus_rd(4'd4, "R11 idr change");
    bus_rd(4'd9, "R12 unmapped");

    random_phase(150, "unlocked");

    // R2 narrow lock writes ignored
    bus_wr(4'd6, 32'h0001_0F0F, 4'h3);
    bus_wr(4'd6, 32'h0000_0F0F, 4'h7);
    bus_wr(4'd6, 32'h0001_0F0F, 4'hE);
    bus_rd(4'd6, "R2 narrow lock write");

    // R4 deviations
    bus_wr(4'd6, 32'h0001_00FF, 4'hF);
    bus_wr(4'd6, 32'h0000_00FE, 4'hF);
    bus_wr(4'd6, 32'h0001_00FE, 4'hF);
    bus_rd(4'd6, "R4 changed mask");
    bus_wr(4'd6, 32'h0001_00FF, 4'hF);
    bus_rd(4'd6, "R4 early read");
    bus_wr(4'd6, 32'h0000_00FF, 4'hF);
    bus_wr(4'd6, 32'h0001_00FF, 4'hF);
    bus_rd(4'd6, "R4 read after partial");
    bus_wr(4'd6, 32'h0001_00FF, 4'hF);
    bus_wr(4'd6, 32'h0001_00FF, 4'hF);
    bus_wr(4'd6, 32'h0001_00FF, 4'hF);
    bus_rd(4'd6, "R4 wrong key");
    check("R4 still unlocked", {255'h0, m_lkd}, 256'h0);

    // R3 proper sequence, interleaved with accesses to other registers
    bus_wr(4'd6, 32'h0001_A5C3, 4'hF);
    bus_wr(4'd5, 32'h0000_1234, 4'h3);
    bus_wr(4'd6, 32'h0000_A5C3, 4'hF);
    bus_rd(4'd0, "R12 mid-sequence read");
    bus_wr(4'd6, 32'h0001_A5C3, 4'hF);
    bus_rd(4'd6, "R3 pre-arm read");
    bus_rd(4'd6, "R3 locked readback");
    check("R3 model locked", {255'h0, m_lkd}, {255'h0, 1'b1});

    // R1 locked fields hold
    bus_wr(4'd0, 32'hFFFF_FFFF, 4'hF);
    bus_rd(4'd0, "R1 mode locked");
    bus_wr(4'd7, 32'h0000_0000, 4'hF);
    bus_rd(4'd7, "R1 af low locked");
    bus_wr(4'd1, 32'hFFFF_FFFF, 4'hF);
    bus_rd(4'd1, "R1 otype locked");
    chk_pins("R1 locked pins");

    // R5 further lock attempts
    bus_wr(4'd6, 32'h0001_0000, 4'hF);
    bus_wr(4'd6, 32'h0000_0000, 4'hF);
    bus_wr(4'd6, 32'h0001_0000, 4'hF);
    bus_rd(4'd6, "R5 relock ignored");

    random_phase(150, "locked");

    // R5 reset releases
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    model_reset();
    m_idr = 0;
    bus_rd(4'd6, "R5 lock cleared by reset");
    bus_wr(4'd0, 32'hFFFF_FFFF, 4'hF);
    bus_rd(4'd0, "R5 mode writable after reset");
    pin_i = $urandom;
    @(negedge clk); m_idr = pin_i;
    chk_pins("post-reset");

    done = 1;
    summary();
  end
endmodule